// File: doc/BRIEF.md
# Limit-Match Counter Timer

A word-addressed counter/timer for one timer slot. It counts up by one unit on every cycle where the tick-enable input is high; in the intended system that input pulses once every 500 ns. The count is kept in the upper field of a 32-bit word. Bits 30..9 hold the count, bits 8..0 always read zero, and bit 31 carries a sticky "reached" flag. Software programs a limit. When the count is about to reach the limit, it reloads to zero on that tick, the reached flag is set and a level interrupt is raised. The timer is therefore periodic with a period of `limit` ticks. A limit of zero selects free-run: the count wraps from its all-ones value (0x7FFFFE00 as a word) to zero and never raises the flag or the interrupt.

Three word offsets are decoded from `bus_addr[ADDR_W-1:2]`:
- Offset 0x0 is the limit register. Reading it acknowledges the interrupt. Writing it restarts the count.
- Offset 0x4 is the read-only count word.
- Offset 0x8 loads the limit without disturbing the running count.

The reached flag and the interrupt come from a three-state controller:
- `S_FREE`: the limit is zero and the flag is clear.
- `S_ARMED`: a nonzero limit is armed and the flag is clear.
- `S_FIRED`: the flag and the interrupt are asserted.

Its transitions are as follows:
- load: a limit write from `S_FREE` or `S_ARMED` goes to `S_ARMED` if the new limit is nonzero, otherwise to `S_FREE`.
- fire: a match in `S_ARMED` goes to `S_FIRED`.
- rematch: a match in `S_FIRED` stays in `S_FIRED`.
- acknowledge: a limit read in `S_FIRED` leaves to `S_ARMED` or `S_FREE`, chosen by the current limit.
- restart: a limit write at 0x0 from any state goes to `S_ARMED` or `S_FREE`, chosen by the new limit.
- retune: a write at 0x8 in `S_FIRED` stays in `S_FIRED`.

Top module: `lmt_timer`

## Requirements
- R1: After reset the limit, the count and the reached flag are zero, `irq` is low, and the counter free-runs.
- R2: Each cycle with `tick_en` high advances the count field (bits 30..9) by one. Without a tick the count holds. Bits 8..0 of `bus_rdata` are always zero.
- R3: With a nonzero limit L, the tick that would bring the count to L instead reloads it to zero and sets the reached flag (bit 31) and `irq`. Counting continues, so the flag is set again every L ticks.
- R4: With a limit of zero, the count wraps from all ones in its field to zero, and the reached flag and `irq` stay low.
- R5: A read at offset 0x0 returns the reached flag in bit 31, the limit in bits 30..9 and zeros below. From the next cycle the flag and `irq` are clear.
- R6: A write at offset 0x0 takes the limit from `bus_wdata[30:9]` and ignores bits 31 and 8..0. It sets the count to zero and clears the flag and `irq`. It wins over a tick in the same cycle.
- R7: A write at offset 0x8 takes the limit from `bus_wdata[30:9]` and leaves the count and the reached flag unchanged. If the new limit is below the count, the count runs on through its wrap before matching.
- R8: A read at offset 0x4 returns the reached flag in bit 31 and the count in bits 30..9, with no side effect. A write at offset 0x4 changes nothing.
- R9: Reads at offset 0x8 and at unmapped offsets (0xC and above) return zero. Writes at unmapped offsets change nothing.
- R10: `irq` is a level that equals the reached flag. Once set, it stays high through further ticks until a read or write at offset 0x0.
- R11: A match and a limit read in the same cycle leave the flag set. The read returns the flag as it was before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-advance pulse (one per 500 ns period) |
| bus_addr | input | ADDR_W | Byte address; bits ADDR_W-1..2 select the word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only; data is combinational) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed word |
| irq | output | 1 | Level interrupt, high while the reached flag is set |

## Verification
The hardest situation to reach is a coincidence: a tick that completes a period landing in the same cycle as the limit read that would acknowledge the flag. Close behind it are a tick landing on a restarting write, and a limit lowered through offset 0x8 beneath the live count, which forces a pass through the wrap. The bench reaches these by driving `tick_en` and the bus strobes on the same falling edge once the count has been stepped to one tick short of the limit. It runs on a 16-bit build with a 6-bit count field, so that every limit value and the full free-run wrap can be swept exhaustively.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
    // Controller states for the reached flag / interrupt
    typedef enum logic [1:0] {
        S_FREE  = 2'd0,
        S_ARMED = 2'd1,
        S_FIRED = 2'd2
    } lmt_state_e;

    // Word indices (byte offset >> 2)
    localparam int IDX_LIMIT    = 0;
    localparam int IDX_COUNT    = 1;
    localparam int IDX_LIM_KEEP = 2;
endpackage

// File: rtl/lmt_bus_decode.sv
module lmt_bus_decode #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int UNIT_LSB = 9,
    localparam int CNT_W   = DATA_W - 1 - UNIT_LSB,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              flag,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  lim_q,
    output logic              wr_rst,
    output logic              wr_keep,
    output logic              rd_lim,
    output logic [CNT_W-1:0]  new_lim,
    output logic [DATA_W-1:0] bus_rdata
);
    import lmt_pkg::*;

    logic [IDX_W-1:0] idx;
    logic             unused_bits;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign new_lim     = bus_wdata[DATA_W-2:UNIT_LSB];
    assign unused_bits = ^{bus_wdata[DATA_W-1], bus_wdata[UNIT_LSB-1:0], bus_addr[1:0]};

    assign wr_rst  = bus_wr && (idx == IDX_W'(IDX_LIMIT));
    assign wr_keep = bus_wr && (idx == IDX_W'(IDX_LIM_KEEP));
    assign rd_lim  = bus_rd && !bus_wr && (idx == IDX_W'(IDX_LIMIT));

    always_comb begin
        bus_rdata = '0;
        if (idx == IDX_W'(IDX_LIMIT)) begin
            bus_rdata = {flag, lim_q, {UNIT_LSB{1'b0}}};
        end else if (idx == IDX_W'(IDX_COUNT)) begin
            bus_rdata = {flag, cnt_q, {UNIT_LSB{1'b0}}};
        end
    end
endmodule

// File: rtl/lmt_count_core.sv
module lmt_count_core #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_rst,
    input  logic             wr_keep,
    input  logic [CNT_W-1:0] new_lim,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] lim_q,
    output logic             match,
    output logic             lim_nz
);
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;
    assign lim_nz  = (lim_q != '0);
    assign match   = tick_en && lim_nz && (cnt_inc == lim_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (wr_rst) begin
            cnt_q <= '0;
            lim_q <= new_lim;
        end else begin
            if (wr_keep) begin
                lim_q <= new_lim;
            end
            if (match) begin
                cnt_q <= '0;
            end else if (tick_en) begin
                cnt_q <= cnt_inc;
            end
        end
    end
endmodule

// File: rtl/lmt_flag_fsm.sv
module lmt_flag_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_rst,
    input  logic wr_keep,
    input  logic rd_lim,
    input  logic match,
    input  logic new_nz,
    input  logic lim_nz,
    output logic flag,
    output logic irq
);
    import lmt_pkg::*;

    lmt_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FREE: begin
                if (wr_rst || wr_keep) begin
                    state_d = new_nz ? S_ARMED : S_FREE;
                end
            end
            S_ARMED: begin
                if (wr_rst) begin
                    state_d = new_nz ? S_ARMED : S_FREE;
                end else if (match) begin
                    state_d = S_FIRED;
                end else if (wr_keep) begin
                    state_d = new_nz ? S_ARMED : S_FREE;
                end
            end
            S_FIRED: begin
                if (wr_rst) begin
                    state_d = new_nz ? S_ARMED : S_FREE;
                end else if (match) begin
                    state_d = S_FIRED;
                end else if (rd_lim) begin
                    state_d = lim_nz ? S_ARMED : S_FREE;
                end
            end
            default: state_d = S_FREE;
        endcase
    end

    always_comb begin
        flag = (state_q == S_FIRED);
        irq  = (state_q == S_FIRED);
    end
endmodule

// File: rtl/lmt_timer.sv
module lmt_timer #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int UNIT_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = DATA_W - 1 - UNIT_LSB;

    logic             wr_rst, wr_keep, rd_lim;
    logic [CNT_W-1:0] new_lim, cnt_q, lim_q;
    logic             match, lim_nz, new_nz, flag;

    assign new_nz = (new_lim != '0);

    lmt_bus_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .UNIT_LSB(UNIT_LSB)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .flag     (flag),
        .cnt_q    (cnt_q),
        .lim_q    (lim_q),
        .wr_rst   (wr_rst),
        .wr_keep  (wr_keep),
        .rd_lim   (rd_lim),
        .new_lim  (new_lim),
        .bus_rdata(bus_rdata)
    );

    lmt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .wr_rst (wr_rst),
        .wr_keep(wr_keep),
        .new_lim(new_lim),
        .cnt_q  (cnt_q),
        .lim_q  (lim_q),
        .match  (match),
        .lim_nz (lim_nz)
    );

    lmt_flag_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_rst (wr_rst),
        .wr_keep(wr_keep),
        .rd_lim (rd_lim),
        .match  (match),
        .new_nz (new_nz),
        .lim_nz (lim_nz),
        .flag   (flag),
        .irq    (irq)
    );
endmodule

// File: rtl/lmt_timer_chk.sv
module lmt_timer_chk #(
    parameter int DATA_W   = 32,
    parameter int UNIT_LSB = 9,
    parameter int CNT_W    = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              irq,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  lim,
    input logic              flag,
    input logic              match,
    input logic              wr_rst,
    input logic              wr_keep,
    input logic              rd_lim
);
    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst_n) begin
            assert_rd_low_zero_R2: assert (bus_rdata[UNIT_LSB-1:0] == '0)
                else $error("low read bits nonzero");
        end
    end

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_rst && !match) |=> (cnt == $past(cnt_inc)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_rst) |=> $stable(cnt));

    assert_match_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !wr_rst) |=> (flag && cnt == '0));

    assert_free_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lim == '0 && !flag) |=> !flag);

    assert_limit_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lim && !match) |=> !irq);

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |=> (cnt == '0 && !irq));

    assert_keep_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_keep && !tick_en) |=> $stable(cnt));

    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_lim && !wr_rst) |=> irq);
endmodule

bind lmt_timer lmt_timer_chk #(
    .DATA_W  (DATA_W),
    .UNIT_LSB(UNIT_LSB),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .irq      (irq),
    .bus_rdata(bus_rdata),
    .cnt      (cnt_q),
    .lim      (lim_q),
    .flag     (flag),
    .match    (match),
    .wr_rst   (wr_rst),
    .wr_keep  (wr_keep),
    .rd_lim   (rd_lim)
);

// File: tb/lmt_timer_tb_top.sv
module lmt_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int AW   = 4;
    localparam int LSB  = 9;
    localparam int CW   = DW - 1 - LSB;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int n_vec = 0;
    int n_bad = 0;

    lmt_timer #(.ADDR_W(AW), .DATA_W(DW), .UNIT_LSB(LSB)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic logic [DW-1:0] word(input bit f, input int c);
        logic [DW-1:0] w;
        w = '0;
        w[DW-1] = f;
        w[DW-2:LSB] = CW'(c);
        return w;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        bus_addr = AW'(addr);
        bus_wdata = data;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input int addr, output logic [DW-1:0] data);
        @(negedge clk);
        bus_addr = AW'(addr);
        bus_rd = 1'b1;
        #1 data = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    logic [DW-1:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, v); check("R1 limit", v, word(0, 0));
        rd(4, v); check("R1 count", v, word(0, 0));
        check("R1 irq", DW'(irq), '0);

        // R2 / R4: free-run full sweep through wrap
        for (int k = 1; k <= CMAX + 1; k++) begin
            ticks(1);
            rd(4, v); check("R2/R4 free count", v, word(0, k % (CMAX + 1)));
            check("R4 free irq", DW'(irq), '0);
        end
        // R2: clocks without tick hold the count
        ticks(3);
        repeat (5) @(negedge clk);
        rd(4, v); check("R2 hold", v, word(0, 3));

        // R3 / R5 / R6 / R10: every nonzero limit
        for (int L = 1; L <= CMAX; L++) begin
            wr(0, DW'((L << LSB) | (1 << (DW-1)) | ((1 << LSB) - 1)));
            rd(4, v); check("R6 restart", v, word(0, 0));
            check("R6 irq low", DW'(irq), '0);
            for (int k = 1; k <= L; k++) begin
                ticks(1);
                rd(4, v); check("R3 count", v, word(k == L, k % L));
                check("R3/R10 irq", DW'(irq), DW'(k == L));
            end
            rd(0, v); check("R5 limit read", v, word(1, L));
            check("R5 irq cleared", DW'(irq), '0);
            rd(4, v); check("R5 flag cleared", v, word(0, 0));
        end

        // R3 periodic + R10 level
        wr(0, word(0, 5));
        ticks(5);
        check("R3 first period", DW'(irq), 1);
        ticks(3);
        check("R10 irq held", DW'(irq), 1);
        rd(4, v); check("R10 count runs", v, word(1, 3));
        ticks(2);
        rd(4, v); check("R3 second period", v, word(1, 0));
        wr(0, word(0, 7));
        check("R10 write clears", DW'(irq), '0);

        // R8: write at 0x4 ignored
        ticks(4);
        wr(4, 16'h7FFF);
        rd(4, v); check("R8 count write ignored", v, word(0, 4));
        rd(0, v); check("R8 limit untouched", v, word(0, 7));

        // R9: unmapped and 0x8 reads zero, unmapped writes ignored
        wr(12, 16'hFFFF);
        rd(12, v); check("R9 unmapped read", v, '0);
        rd(8, v); check("R9 keep-offset read", v, '0);
        rd(4, v); check("R9 count unchanged", v, word(0, 4));
        rd(0, v); check("R9 limit unchanged", v, word(0, 7));

        // R7: limit change without restart
        wr(0, word(0, 40));
        ticks(10);
        wr(8, word(0, 20));
        rd(4, v); check("R7 count kept", v, word(0, 10));
        ticks(9);
        check("R7 not yet", DW'(irq), '0);
        ticks(1);
        rd(4, v); check("R7 match new limit", v, word(1, 0));
        // R7: keep-write leaves flag set
        wr(8, word(0, 30));
        check("R7 flag kept", DW'(irq), 1);
        rd(0, v); check("R7 limit", v, word(1, 30));
        // R7: new limit below count runs through wrap
        wr(0, word(0, 40));
        ticks(30);
        wr(8, word(0, 10));
        ticks(CMAX - 30 + 1);
        rd(4, v); check("R7 wrapped", v, word(0, 0));
        ticks(9);
        check("R7 before match", DW'(irq), '0);
        ticks(1);
        check("R7 after wrap match", DW'(irq), 1);

        // R11: match coincides with limit read
        wr(0, word(0, 5));
        ticks(4);
        @(negedge clk);
        tick_en = 1'b1; bus_addr = '0; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        tick_en = 1'b0; bus_rd = 1'b0;
        check("R11 read value", v, word(0, 5));
        check("R11 flag kept", DW'(irq), 1);
        rd(4, v); check("R11 count", v, word(1, 0));

        // R6: restart wins over a tick in the same cycle
        ticks(3);
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = '0; bus_wdata = word(0, 9);
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(4, v); check("R6 restart over tick", v, word(0, 0));
        check("R6 irq cleared", DW'(irq), '0);

        // R4: limit zero again after limited use
        wr(0, '0);
        ticks(CMAX + 2);
        rd(4, v); check("R4 free again", v, word(0, 1));
        check("R4 no irq", DW'(irq), '0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule